// File: doc/BRIEF.md
# Macrocycle Timer with External Synchronisation

This block paces the macrocycles of a fieldbus master. A down-counter is loaded with a programmed macrocycle length and counts one step per clock. Three control inputs decide what restarts it. In internal mode the counter restarts by itself when it expires, or when software issues a one-clock start pulse. In external mode every rising edge of the sync input restarts it. In gated external mode an edge restarts it only while the processor reports that the periodic part of the current macrocycle has finished.

Alongside the timer the block keeps two counters. One counts restarts, which is the number of macrocycles. The other counts every rising edge of the sync input in every mode, including edges that did not restart the timer, so that a pulse source running at the wrong rate can still be seen. It also gates the two sync indicator LED outputs. The sync input arrives already synchronised and filtered.

Top module: `mcyc_timer`

## Requirements
- R1: When `sync_dis_i` is 1 (internal mode), the timer reloads `len_i` on a `sw_start_i` pulse and again in the cycle after it has shown zero, so that a free-running macrocycle lasts `len_i`+1 clocks. Sync edges do not reload it in this mode.
- R2: When `sync_dis_i` is 0 and `opt_i` is 0, every rising edge of `sync_i` reloads the timer with `len_i`, whatever the value of `safe_i`.
- R3: When `sync_dis_i` is 0 and `opt_i` is 1, a rising edge reloads the timer only while `safe_i` is 1 (periodic part done). An edge seen while `safe_i` is 0 (processor busy) changes neither the timer nor the macrocycle number.
- R4: The timer steps down by one per clock when it is not zero and not reloaded. In the external modes it holds at zero after expiry until the next qualifying edge. `zero_p_o` is high for exactly one clock, in the first cycle that `cnt_o` reads zero.
- R5: `pcnt_o` increases by one for each rising edge of `sync_i` in every mode, including edges that are ignored for reload. A level held high counts only once.
- R6: `pcnt_o` is cleared by reset or by `pcnt_clr_i` being 1. The clear takes priority over a simultaneous edge.
- R7: `num_o` increases by one on each reload and wraps to 0 after its all-ones value.
- R8: When `sync_dis_i` is 0, `led_act_n_o` and `led_err_n_o` are the inverses of `led_act_i` and `led_err_i` (active low). When `sync_dis_i` is 1, both are forced to 0.
- R9: After reset, `cnt_o`, `num_o` and `pcnt_o` read 0 and `zero_p_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous core reset, active high |
| sync_i | input | 1 | Synchronised external sync level |
| sync_dis_i | input | 1 | 1 selects internal timing, 0 enables the sync input |
| opt_i | input | 1 | 0: every edge reloads; 1: edges gated by `safe_i` |
| safe_i | input | 1 | 1 when the processor accepts a new macrocycle |
| pcnt_clr_i | input | 1 | Clears the sync edge counter while 1 |
| sw_start_i | input | 1 | One-clock software start pulse (internal mode) |
| len_i | input | LEN_W | Macrocycle length in clocks |
| led_act_i | input | 1 | Sync activity indicator request |
| led_err_i | input | 1 | Sync error indicator request |
| cnt_o | output | LEN_W | Current timer value |
| zero_p_o | output | 1 | One-clock pulse when the timer reaches zero |
| num_o | output | NUM_W | Number of macrocycles started |
| pcnt_o | output | PCNT_W | Number of sync rising edges |
| led_act_n_o | output | 1 | Activity LED, active low, 0 in internal mode |
| led_err_n_o | output | 1 | Error LED, active low, 0 in internal mode |

## Verification
The bench builds the block with an 8-bit length, a 4-bit macrocycle number and an 8-bit edge counter. The narrow macrocycle number lets sixteen reloads carry it across its wrap to zero, and the short length lets whole internal-mode periods, the expiry hold and the doubled-rate pulse case with a 20-clock length and 10-clock pulse spacing run in a few hundred clocks. The stimulus table steps through all three modes with and without the safe flag to show which edges reload the timer and that every edge is counted.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic [1:0] {
        MODE_INTERNAL  = 2'd0,
        MODE_EXT_ALL   = 2'd1,
        MODE_EXT_GATED = 2'd2
    } mode_e;

endpackage

// File: rtl/mcyc_edge_det.sv
module mcyc_edge_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic rise_p_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_p_o = lvl_i & ~st_q.prev;

endmodule

// File: rtl/mcyc_mode_sel.sv
module mcyc_mode_sel
    import mcyc_pkg::*;
(
    input  logic sync_dis_i,
    input  logic opt_i,
    input  logic safe_i,
    input  logic rise_p_i,
    input  logic zero_p_i,
    input  logic sw_start_i,
    output logic load_o
);

    mode_e mode;

    always_comb begin
        if (sync_dis_i) begin
            mode = MODE_INTERNAL;
        end else if (opt_i) begin
            mode = MODE_EXT_GATED;
        end else begin
            mode = MODE_EXT_ALL;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_INTERNAL:  load_o = zero_p_i | sw_start_i;
            MODE_EXT_ALL:   load_o = rise_p_i;
            MODE_EXT_GATED: load_o = rise_p_i & safe_i;
            default:        load_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mcyc_downcnt.sv
module mcyc_downcnt #(
    parameter int W = 31
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_p_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         zp;
    } dc_st_t;

    dc_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.zp = 1'b0;
        if (load_i) begin
            st_d.cnt = len_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
            st_d.zp  = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign zero_p_o = st_q.zp;

endmodule

// File: rtl/mcyc_evcnt.sv
module mcyc_evcnt #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ev_st_t;

    ev_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/mcyc_timer.sv
module mcyc_timer #(
    parameter int LEN_W  = 31,
    parameter int NUM_W  = 32,
    parameter int PCNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sync_i,
    input  logic              sync_dis_i,
    input  logic              opt_i,
    input  logic              safe_i,
    input  logic              pcnt_clr_i,
    input  logic              sw_start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              led_act_i,
    input  logic              led_err_i,
    output logic [LEN_W-1:0]  cnt_o,
    output logic              zero_p_o,
    output logic [NUM_W-1:0]  num_o,
    output logic [PCNT_W-1:0] pcnt_o,
    output logic              led_act_n_o,
    output logic              led_err_n_o
);

    logic rise_p;
    logic load_p;
    logic zero_p;

    mcyc_edge_det u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .lvl_i    (sync_i),
        .rise_p_o (rise_p)
    );

    mcyc_mode_sel u_mode (
        .sync_dis_i (sync_dis_i),
        .opt_i      (opt_i),
        .safe_i     (safe_i),
        .rise_p_i   (rise_p),
        .zero_p_i   (zero_p),
        .sw_start_i (sw_start_i),
        .load_o     (load_p)
    );

    mcyc_downcnt #(.W(LEN_W)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load_p),
        .len_i    (len_i),
        .cnt_o    (cnt_o),
        .zero_p_o (zero_p)
    );

    mcyc_evcnt #(.W(NUM_W)) u_num (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (1'b0),
        .inc_i (load_p),
        .cnt_o (num_o)
    );

    mcyc_evcnt #(.W(PCNT_W)) u_pcnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (pcnt_clr_i),
        .inc_i (rise_p),
        .cnt_o (pcnt_o)
    );

    assign zero_p_o    = zero_p;
    assign led_act_n_o = sync_dis_i ? 1'b0 : ~led_act_i;
    assign led_err_n_o = sync_dis_i ? 1'b0 : ~led_err_i;

endmodule

// File: rtl/mcyc_timer_chk.sv
module mcyc_timer_chk #(
    parameter int LEN_W  = 31,
    parameter int NUM_W  = 32,
    parameter int PCNT_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sync_i,
    input logic              sync_dis_i,
    input logic              opt_i,
    input logic              safe_i,
    input logic              pcnt_clr_i,
    input logic              sw_start_i,
    input logic [LEN_W-1:0]  cnt_o,
    input logic              zero_p_o,
    input logic [NUM_W-1:0]  num_o,
    input logic [PCNT_W-1:0] pcnt_o,
    input logic              led_act_n_o,
    input logic              led_err_n_o
);

    // R1: internal mode, no start, no expiry, nonzero -> step down
    assert_int_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (sync_dis_i && !sw_start_i && !zero_p_o && cnt_o != '0)
        |=> (cnt_o == $past(cnt_o) - LEN_W'(1)));

    // R2: external modes, no sync high -> no new macrocycle
    assert_ext_no_edge_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sync_dis_i && !sync_i) |=> $stable(num_o));

    // R3: gated mode while busy -> no new macrocycle
    assert_gated_busy_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sync_dis_i && opt_i && !safe_i) |=> $stable(num_o));

    // R4: zero pulse only at zero and never two in a row
    assert_zp_at_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        zero_p_o |-> (cnt_o == '0));
    assert_zp_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        zero_p_o |=> !zero_p_o);

    // R5: no sync high and no clear -> edge count unchanged
    assert_pcnt_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sync_i && !pcnt_clr_i) |=> $stable(pcnt_o));

    // R6: clear empties the edge count
    assert_pcnt_clr_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        pcnt_clr_i |=> (pcnt_o == '0));

    // R7: macrocycle number only moves by one
    assert_num_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(num_o) |-> (num_o == $past(num_o) + NUM_W'(1)));

    // R8: internal mode silences the sync LEDs
    assert_led_off_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_dis_i |-> (!led_act_n_o && !led_err_n_o));

endmodule

bind mcyc_timer mcyc_timer_chk #(
    .LEN_W  (LEN_W),
    .NUM_W  (NUM_W),
    .PCNT_W (PCNT_W)
) u_mcyc_timer_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sync_i      (sync_i),
    .sync_dis_i  (sync_dis_i),
    .opt_i       (opt_i),
    .safe_i      (safe_i),
    .pcnt_clr_i  (pcnt_clr_i),
    .sw_start_i  (sw_start_i),
    .cnt_o       (cnt_o),
    .zero_p_o    (zero_p_o),
    .num_o       (num_o),
    .pcnt_o      (pcnt_o),
    .led_act_n_o (led_act_n_o),
    .led_err_n_o (led_err_n_o)
);

// File: tb/test_mcyc_timer.sv
`timescale 1ns/1ps
module test_mcyc_timer;

    localparam int LEN_W  = 8;
    localparam int NUM_W  = 4;
    localparam int PCNT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sync = 1'b0;
    logic              dis = 1'b0;
    logic              opt = 1'b0;
    logic              safe = 1'b0;
    logic              pclr = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  len = '0;
    logic              lact = 1'b0;
    logic              lerr = 1'b0;
    logic [LEN_W-1:0]  cnt;
    logic              zp;
    logic [NUM_W-1:0]  num;
    logic [PCNT_W-1:0] pcnt;
    logic              lact_n, lerr_n;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcyc_timer #(.LEN_W(LEN_W), .NUM_W(NUM_W), .PCNT_W(PCNT_W)) i_mcyc_timer (
        .clk_i(clk), .rst_i(rst), .sync_i(sync), .sync_dis_i(dis), .opt_i(opt),
        .safe_i(safe), .pcnt_clr_i(pclr), .sw_start_i(start), .len_i(len),
        .led_act_i(lact), .led_err_i(lerr), .cnt_o(cnt), .zero_p_o(zp),
        .num_o(num), .pcnt_o(pcnt), .led_act_n_o(lact_n), .led_err_n_o(lerr_n)
    );

    // fields: dis, opt, safe, pulse, expected reload, expected edge count step
    localparam logic [5:0] VEC [0:7] = '{
        6'b000111, 6'b001111, 6'b000000, 6'b010101,
        6'b011111, 6'b011000, 6'b100101, 6'b111101
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sync = 1'b1;
        tick(1);
        sync = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int n0, p0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        chk("R9 cnt", int'(cnt), 0);
        chk("R9 num", int'(num), 0);
        chk("R9 pcnt", int'(pcnt), 0);
        chk("R9 zp", int'(zp), 0);

        // table walk: R2, R3, R5, R1 (pulse ignored internally)
        len = 8'd200;
        for (int i = 0; i < 8; i++) begin
            logic [5:0] v;
            v = VEC[i];
            dis = v[5]; opt = v[4]; safe = v[3];
            tick(1);
            n0 = int'(num); p0 = int'(pcnt);
            if (v[2]) begin
                pulse();
                tick(1);
            end else begin
                tick(2);
            end
            chk($sformatf("R2/R3/R1 row%0d reload", i), (int'(num) - n0) & 15, int'(v[1]));
            chk($sformatf("R5 row%0d edges", i), int'(pcnt) - p0, int'(v[0]));
        end

        // R1 internal free-running period len+1
        dis = 1'b1; len = 8'd5;
        tick(1);
        n0 = int'(num);
        start = 1'b1;
        tick(1);
        start = 1'b0;
        chk("R1 start load", int'(cnt), 5);
        chk("R1 start num", int'(num), (n0 + 1) & 15);
        for (int k = 4; k >= 0; k--) begin
            tick(1);
            chk("R1 count", int'(cnt), k);
            chk("R4 zp", int'(zp), (k == 0) ? 1 : 0);
        end
        tick(1);
        chk("R1 auto reload", int'(cnt), 5);
        chk("R1 auto num", int'(num), (n0 + 2) & 15);

        // R4 hold at zero in external mode, single zero pulse
        dis = 1'b0; opt = 1'b0; len = 8'd3;
        tick(1);
        pulse();
        chk("R2 load", int'(cnt), 3);
        begin
            int zc;
            zc = 0;
            for (int k = 0; k < 12; k++) begin
                tick(1);
                zc += int'(zp);
            end
            chk("R4 one zero pulse", zc, 1);
            chk("R4 hold zero", int'(cnt), 0);
        end

        // R3 doubled pulse rate, every other pulse ignored
        dis = 1'b0; opt = 1'b1; len = 8'd20;
        tick(1);
        for (int k = 0; k < 6; k++) begin
            n0 = int'(num); p0 = int'(pcnt);
            safe = k[0];
            pulse();
            safe = 1'b0;
            chk("R3 gated reload", (int'(num) - n0) & 15, k[0] ? 1 : 0);
            chk("R5 gated edges", int'(pcnt) - p0, 1);
            if (k[0]) chk("R3 gated load value", int'(cnt), 20);
            else if (k > 0) chk("R3 ignored keeps count", int'(cnt), 10);
            tick(9);
        end

        // R7 wrap of macrocycle number
        opt = 1'b0;
        n0 = int'(num);
        for (int k = 1; k <= 16; k++) begin
            pulse();
            tick(1);
            chk("R7 num step", int'(num), (n0 + k) & 15);
        end
        chk("R7 wrap back", int'(num), n0);

        // R5 held level counts once
        p0 = int'(pcnt);
        sync = 1'b1;
        tick(5);
        sync = 1'b0;
        tick(1);
        chk("R5 level once", int'(pcnt), (p0 + 1) & 255);

        // R6 clear, and clear beats simultaneous edge
        pclr = 1'b1;
        tick(1);
        pclr = 1'b0;
        chk("R6 clear", int'(pcnt), 0);
        pulse();
        chk("R6 count after clear", int'(pcnt), 1);
        tick(1);
        pclr = 1'b1; sync = 1'b1;
        tick(1);
        pclr = 1'b0; sync = 1'b0;
        chk("R6 clear priority", int'(pcnt), 0);

        // R8 LEDs
        dis = 1'b0; lact = 1'b1; lerr = 1'b0;
        #1;
        chk("R8 act on", int'(lact_n), 0);
        chk("R8 err off", int'(lerr_n), 1);
        dis = 1'b1; lact = 1'b0; lerr = 1'b0;
        #1;
        chk("R8 act forced", int'(lact_n), 0);
        chk("R8 err forced", int'(lerr_n), 0);
        tick(1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule